// File: doc/BRIEF.md
# Trigger-Out Logic Composer

This block produces the single registered signal that drives a board's front-panel general-purpose output, so that a trigger can be passed on to other boards. It first builds a trigger term. The software trigger and the external trigger each join this term when their own enable bits are set. The per-channel self-trigger requests also join it, but only after they have been gated by a mask and combined in one of three ways: any-of (OR), all-of (AND), or a count compared against a programmable level (majority).

A four-way selector then chooses what reaches the pin. The choices are the trigger term, a motherboard probe, a piggyback probe, or a synchronisation input. The selected value passes through one flip-flop before it leaves the block, so the pin carries no combinational glitches.

The configuration fields come in as static ports, which a register file outside the block supplies. The electrical output standard, the generation of the probe signals and the acquisition trigger path are handled elsewhere.

Top module: `trig_out_composer`

## Requirements
- R1: While `rst_n` is low, `gpo` is 0, and it stays 0 at the first rising edge after reset is released when the inputs that edge samples select nothing active.
- R2: A self-trigger request whose bit in `cfg_mask` is 0 has no effect on the self-trigger result.
- R3: With `cfg_logic` = 2'b00, the self-trigger result is 1 when any masked request is high.
- R4: With `cfg_logic` = 2'b01, the self-trigger result is 1 only when every masked request is high. An all-zero mask gives 0.
- R5: With `cfg_logic` = 2'b10, the self-trigger result is 1 when the number of high masked requests is strictly greater than `cfg_level`.
- R6: With `cfg_logic` = 2'b11 (reserved), the self-trigger result is 0.
- R7: The trigger term is (`sw_trg` AND `cfg_sw_en`) OR (`ext_trg` AND `cfg_ext_en`) OR the self-trigger result. With `cfg_sw_en`=1, `cfg_ext_en`=0 and `cfg_mask`=0, only the software trigger reaches the output.
- R8: `cfg_src` selects what appears on `gpo`: 2'b00 gives the trigger term, 2'b01 gives `mb_probe`, 2'b10 gives `pb_probe`, and 2'b11 gives `sync_in`.
- R9: `gpo` is registered. It shows the value computed from the inputs sampled at the previous rising edge of `clk`, so there is exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| self_trg | input | N_SELF | Per-channel self-trigger requests |
| sw_trg | input | 1 | Software trigger pulse |
| ext_trg | input | 1 | External trigger input |
| mb_probe | input | 1 | Motherboard probe signal |
| pb_probe | input | 1 | Piggyback probe signal |
| sync_in | input | 1 | Synchronisation input |
| cfg_mask | input | N_SELF | Self-trigger participation mask |
| cfg_logic | input | 2 | Self-trigger combine mode |
| cfg_level | input | LVL_W | Majority threshold (count must exceed it) |
| cfg_sw_en | input | 1 | Software trigger joins the trigger term |
| cfg_ext_en | input | 1 | External trigger joins the trigger term |
| cfg_src | input | 2 | Output source select |
| gpo | output | 1 | Registered general-purpose output |

## Verification
The random vectors change every input on every cycle. Because of this, a design that adds or drops a register stage, swaps two selector codes or mixes up the combine modes gives different answers on many cycles. The bench biases the masks toward all-zero and all-one patterns, so the empty-mask AND case, the full AND case and unmasked activity all occur often. These cases separate a correct AND from one that ignores the mask or returns 1 on an empty set.

The directed cases set the number of active requests equal to the majority level and then one above it. This separates "greater than" from "greater or equal". The directed cases also drive the reserved mode with all requests active, and they run the default software-only setup with the external trigger and the self-triggers active, to show that neither of them leaks through.

// File: rtl/trgo_pkg.sv
// Package: shared encodings for the trigger-out composer.
// Assumes the 2-bit codes below match the configuration register fields.
package trgo_pkg;

    typedef enum logic [1:0] {
        COMB_OR   = 2'b00,
        COMB_AND  = 2'b01,
        COMB_MAJ  = 2'b10,
        COMB_RSVD = 2'b11
    } comb_mode_e;

    typedef enum logic [1:0] {
        SRC_TRIG = 2'b00,
        SRC_MB   = 2'b01,
        SRC_PB   = 2'b10,
        SRC_SYNC = 2'b11
    } src_sel_e;

endpackage

// File: rtl/trgo_self_combine.sv
// Module: trgo_self_combine
// Combines masked self-trigger requests by OR, AND or majority (count > level).
// Assumes: combinational only; an empty mask yields 0 in every mode;
// the reserved mode yields 0.
module trgo_self_combine
    import trgo_pkg::*;
#(
    parameter int N_SELF = 8,
    parameter int LVL_W  = 3
) (
    input  logic [N_SELF-1:0] req,
    input  logic [N_SELF-1:0] mask,
    input  logic [1:0]        mode,
    input  logic [LVL_W-1:0]  level,
    output logic              hit
);
    localparam int CNT_W = $clog2(N_SELF + 1);
    localparam int CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W;

    logic [N_SELF-1:0] gated;
    logic [CNT_W-1:0]  active_cnt;
    logic              any_hit;
    logic              all_hit;
    logic              maj_hit;

    // Gate requests with the mask.
    always_comb gated = req & mask;

    // Count active masked requests.
    always_comb begin
        active_cnt = '0;
        for (int i = 0; i < N_SELF; i++) begin
            active_cnt = active_cnt + CNT_W'(gated[i]);
        end
    end

    // Per-mode terms; AND requires a non-empty mask.
    always_comb begin
        any_hit = |gated;
        all_hit = (mask != '0) && (gated == mask);
        maj_hit = CMP_W'(active_cnt) > CMP_W'(level);
    end

    // Pick the term for the selected mode.
    always_comb begin
        unique case (comb_mode_e'(mode))
            COMB_OR:  hit = any_hit;
            COMB_AND: hit = all_hit;
            COMB_MAJ: hit = maj_hit;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/trgo_out_mux.sv
// Module: trgo_out_mux
// Four-way selector choosing the value driven to the output register.
// Assumes: combinational; every code is defined.
module trgo_out_mux
    import trgo_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       trig,
    input  logic       mb,
    input  logic       pb,
    input  logic       sync,
    output logic       y
);
    // Select one source per code.
    always_comb begin
        unique case (src_sel_e'(sel))
            SRC_TRIG: y = trig;
            SRC_MB:   y = mb;
            SRC_PB:   y = pb;
            default:  y = sync;
        endcase
    end

endmodule

// File: rtl/trig_out_composer.sv
// Module: trig_out_composer (top)
// Builds the trigger term from enabled software/external triggers and the
// combined self-triggers, selects the output source and registers it.
// Assumes: configuration is static or changes synchronously to clk;
// synchronous active-low reset clears the output.
module trig_out_composer #(
    parameter int N_SELF = 8,
    parameter int LVL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SELF-1:0] self_trg,
    input  logic              sw_trg,
    input  logic              ext_trg,
    input  logic              mb_probe,
    input  logic              pb_probe,
    input  logic              sync_in,
    input  logic [N_SELF-1:0] cfg_mask,
    input  logic [1:0]        cfg_logic,
    input  logic [LVL_W-1:0]  cfg_level,
    input  logic              cfg_sw_en,
    input  logic              cfg_ext_en,
    input  logic [1:0]        cfg_src,
    output logic              gpo
);
    logic self_hit;
    logic trig_term;
    logic mux_y;

    trgo_self_combine #(.N_SELF(N_SELF), .LVL_W(LVL_W)) u_comb (
        .req   (self_trg),
        .mask  (cfg_mask),
        .mode  (cfg_logic),
        .level (cfg_level),
        .hit   (self_hit)
    );

    // OR the enabled direct sources with the self-trigger result.
    always_comb trig_term = (sw_trg & cfg_sw_en) | (ext_trg & cfg_ext_en) | self_hit;

    trgo_out_mux u_mux (
        .sel  (cfg_src),
        .trig (trig_term),
        .mb   (mb_probe),
        .pb   (pb_probe),
        .sync (sync_in),
        .y    (mux_y)
    );

    // Glitch-free output register.
    always_ff @(posedge clk) begin
        if (!rst_n) gpo <= 1'b0;
        else        gpo <= mux_y;
    end

endmodule

// File: rtl/trig_out_composer_checker.sv
// Module: trig_out_composer_checker
// Temporal properties of the composer's output, attached by bind.
module trig_out_composer_checker #(
    parameter int N_SELF = 8,
    parameter int LVL_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SELF-1:0] self_trg,
    input logic              sw_trg,
    input logic              ext_trg,
    input logic              mb_probe,
    input logic              pb_probe,
    input logic              sync_in,
    input logic [N_SELF-1:0] cfg_mask,
    input logic [1:0]        cfg_logic,
    input logic [LVL_W-1:0]  cfg_level,
    input logic              cfg_sw_en,
    input logic              cfg_ext_en,
    input logic [1:0]        cfg_src,
    input logic              gpo
);
    // R8: motherboard probe passes after one cycle (R9).
    a_r8_mb_probe: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_src == 2'b01) |=> (gpo == $past(mb_probe)));

    // R8: piggyback probe passes.
    a_r8_pb_probe: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_src == 2'b10) |=> (gpo == $past(pb_probe)));

    // R8: sync input passes.
    a_r8_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_src == 2'b11) |=> (gpo == $past(sync_in)));

    // R6: reserved mode contributes nothing.
    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_src == 2'b00 && cfg_logic == 2'b11 && !cfg_sw_en && !cfg_ext_en) |=> !gpo);

    // R4: AND over an empty mask is 0.
    a_r4_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_src == 2'b00 && cfg_logic == 2'b01 && cfg_mask == '0
         && !cfg_sw_en && !cfg_ext_en) |=> !gpo);

    // R2: requests outside the mask cannot fire the output in OR mode.
    a_r2_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_src == 2'b00 && cfg_logic == 2'b00 && (self_trg & cfg_mask) == '0
         && !cfg_sw_en && !cfg_ext_en) |=> !gpo);

    // R7: enabled software trigger reaches the output.
    a_r7_sw_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_src == 2'b00 && cfg_sw_en && sw_trg) |=> gpo);

    // R7: enabled external trigger reaches the output.
    a_r7_ext_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_src == 2'b00 && cfg_ext_en && ext_trg) |=> gpo);

endmodule

bind trig_out_composer trig_out_composer_checker #(.N_SELF(N_SELF), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/trig_out_composer_test.sv
module trig_out_composer_test;
    localparam int  N_SELF  = 8;
    localparam int  LVL_W   = 3;
    localparam time CLK_PER = 10;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [N_SELF-1:0] self_trg;
    logic              sw_trg, ext_trg, mb_probe, pb_probe, sync_in;
    logic [N_SELF-1:0] cfg_mask;
    logic [1:0]        cfg_logic;
    logic [LVL_W-1:0]  cfg_level;
    logic              cfg_sw_en, cfg_ext_en;
    logic [1:0]        cfg_src;
    logic              gpo;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    trig_out_composer #(.N_SELF(N_SELF), .LVL_W(LVL_W)) uut (
        .clk(clk), .rst_n(rst_n), .self_trg(self_trg), .sw_trg(sw_trg),
        .ext_trg(ext_trg), .mb_probe(mb_probe), .pb_probe(pb_probe),
        .sync_in(sync_in), .cfg_mask(cfg_mask), .cfg_logic(cfg_logic),
        .cfg_level(cfg_level), .cfg_sw_en(cfg_sw_en), .cfg_ext_en(cfg_ext_en),
        .cfg_src(cfg_src), .gpo(gpo)
    );

    // Reference self-trigger result from R2..R6.
    function automatic logic ref_self();
        int cnt = 0;
        logic [N_SELF-1:0] g = self_trg & cfg_mask;
        for (int i = 0; i < N_SELF; i++) cnt += int'(g[i]);
        case (cfg_logic)
            2'b00:   return cnt > 0;
            2'b01:   return (cfg_mask != 0) && (cnt == $countones(cfg_mask));
            2'b10:   return cnt > int'(cfg_level);
            default: return 1'b0;
        endcase
    endfunction

    // Reference output value from R7, R8.
    function automatic logic ref_out();
        logic t = (sw_trg & cfg_sw_en) | (ext_trg & cfg_ext_en) | ref_self();
        case (cfg_src)
            2'b00:   return t;
            2'b01:   return mb_probe;
            2'b10:   return pb_probe;
            default: return sync_in;
        endcase
    endfunction

    function automatic string tag_of();
        if (cfg_src != 2'b00) return "R8";
        case (cfg_logic)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic exp);
        n_checks++;
        if (gpo !== exp) begin
            n_fail++;
            $display("FAIL %s: gpo=%b expected=%b at %0t", tag, gpo, exp, $time);
        end
    endtask

    // Apply current inputs at negedge; check one edge later (R9).
    task automatic step(input string tag);
        logic exp;
        string t;
        exp = ref_out();
        t = tag;
        @(posedge clk);
        #1;
        check(t, exp);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        self_trg = '0; sw_trg = 0; ext_trg = 0; mb_probe = 0; pb_probe = 0; sync_in = 0;
        cfg_mask = '0; cfg_logic = 2'b00; cfg_level = '0;
        cfg_sw_en = 1'b1; cfg_ext_en = 1'b0; cfg_src = 2'b00;
    endtask

    initial begin
        #(CLK_PER * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: expired expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_inputs();
        sw_trg = 1'b1; mb_probe = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", 1'b0);                       // R1: held low in reset
        @(negedge clk);
        rst_n = 1'b1;
        sw_trg = 1'b0; mb_probe = 1'b0;
        step("R1");                              // R1: nothing active after release

        // R7: default software-only setup
        ext_trg = 1'b1; self_trg = '1;
        step("R7");                              // ext and self blocked
        sw_trg = 1'b1;
        step("R7");
        sw_trg = 1'b0; ext_trg = 1'b0;
        step("R9");                              // R9: single cycle pulse returns low
        cfg_ext_en = 1'b1; ext_trg = 1'b1; cfg_sw_en = 1'b0;
        step("R7");

        // R2/R3: mask gating in OR mode
        cfg_ext_en = 1'b0; ext_trg = 1'b0;
        cfg_mask = 8'h0F; self_trg = 8'hF0;
        step("R2");
        self_trg = 8'h10 | 8'h04;
        step("R3");

        // R4: AND full, partial, empty
        cfg_logic = 2'b01; cfg_mask = 8'hFF; self_trg = 8'hFF;
        step("R4");
        self_trg = 8'hFE;
        step("R4");
        cfg_mask = 8'h00; self_trg = 8'hFF;
        step("R4");

        // R5: majority boundary at level 2
        cfg_logic = 2'b10; cfg_mask = 8'hFF; cfg_level = 3'd2; self_trg = 8'h03;
        step("R5");
        self_trg = 8'h07;
        step("R5");
        cfg_level = 3'd7; self_trg = 8'hFF;
        step("R5");

        // R6: reserved with everything active
        cfg_logic = 2'b11; self_trg = 8'hFF;
        step("R6");

        // R8: each source code
        for (int s = 1; s < 4; s++) begin
            cfg_src = 2'(s);
            mb_probe = (s == 1); pb_probe = (s == 2); sync_in = (s == 3);
            step("R8");
            mb_probe = (s != 1); pb_probe = (s != 2); sync_in = (s != 3);
            step("R8");
        end

        // Random vectors
        for (int v = 0; v < 3000; v++) begin
            int sel = $urandom_range(0, 3);
            self_trg   = N_SELF'($urandom);
            cfg_mask   = (sel == 0) ? '0 : (sel == 1) ? '1 : N_SELF'($urandom);
            if ($urandom_range(0, 3) == 0) self_trg = '1;
            cfg_logic  = 2'($urandom);
            cfg_level  = LVL_W'($urandom);
            cfg_sw_en  = 1'($urandom); cfg_ext_en = 1'($urandom);
            sw_trg     = 1'($urandom); ext_trg    = 1'($urandom);
            mb_probe   = 1'($urandom); pb_probe   = 1'($urandom);
            sync_in    = 1'($urandom);
            cfg_src    = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00;
            step(tag_of());
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule